// File: doc/BRIEF.md
# HyperBus Transaction Sequencer

This block sits between a 16-bit memory-mapped client port with burst support and the I/O cells of a HyperRAM-style device. It runs in the same clock domain as the device clock. Each client read or write becomes one device transaction. The block lowers chip select and sends a three-cycle command/address phase. It then waits out an initial latency and moves one 16-bit word per clock cycle, which is two bytes at double data rate. It raises chip select again and keeps it high for a recovery period before it accepts the next request.

During the first command cycle the block samples the device's read-write strobe. That level selects single or doubled latency. On writes the block drives the strobe as a per-byte mask. On reads the receive path is a small FIFO fed by the strobe itself, so its first output word lags. The block therefore issues one clock more than the burst length and drops the first word the FIFO delivers. The physical DDR cells, the phase-shifted clocks, the input delay and the device configuration belong to other blocks.

Top module: `hbus_seq`

## Requirements
- R1: While idle, `av_waitrequest` is low, `hb_cs_n` is high and `hb_ck_en` is low. From the cycle after a request is accepted until the transaction ends, `av_waitrequest` stays high, except in write data cycles that take a client beat. If read and write are both asserted, the read is taken.
- R2: The command/address phase lasts 3 clock cycles with chip select low, the clock running and DQ driven. It sends a 48-bit word as bits 47:32, then 31:16, then 15:0. Bit 47 is 1 for a read and 0 for a write. Bit 46 is 0, selecting memory space. Bit 45 is 1, selecting a linear burst. Bits 44:16 carry word address bits above bit 2. Bits 15:3 are zero. Bits 2:0 carry the low three word address bits.
- R3: `hb_rwds_i` is sampled in the first command cycle. If it is low, LAT_CYC latency cycles follow. If it is high, 2*LAT_CYC latency cycles follow. During latency chip select stays low, the clock runs and DQ is not driven.
- R4: The first write beat is captured together with the command. It is sent in the first data cycle while `av_waitrequest` is still high. Each later beat is taken in a cycle with `av_waitrequest` low and `av_write` high, and goes out on `hb_dq_o` in that same cycle.
- R5: During write data `hb_rwds_oe` is high and `hb_rwds_o` is the inverse of `av_byteenable`. Bit 1 covers `hb_dq_o[15:8]` and bit 0 covers `hb_dq_o[7:0]`. A 1 means the byte is not written.
- R6: A write data cycle without `av_write` (after the held first beat) stops the clock. Chip select stays low and no beat is consumed.
- R7: A read of N words runs N+1 data clocks with chip select low. Chip select then rises while the block waits for the remaining words.
- R8: On a read, the first word the receive FIFO returns is discarded. The next N words appear on `av_readdata` with `av_readdatavalid`, unchanged and in order. After the last word no further word is forwarded.
- R9: After every transaction chip select stays high and `av_waitrequest` stays high for RECOV_CYC cycles before the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and device clock |
| rst | input | 1 | Synchronous reset, active high |
| av_address | input | ADDR_W | Word address of the burst |
| av_read | input | 1 | Read request |
| av_write | input | 1 | Write request or write beat |
| av_writedata | input | 16 | Write beat data |
| av_byteenable | input | 2 | Byte enables of the write beat |
| av_burstcount | input | BURST_W | Burst length in words, at least 1 |
| av_waitrequest | output | 1 | Request or beat not taken this cycle |
| av_readdata | output | 16 | Read word |
| av_readdatavalid | output | 1 | Read word valid |
| hb_cs_n | output | 1 | Device chip select, active low |
| hb_ck_en | output | 1 | Enables one device clock period this cycle |
| hb_dq_o | output | 16 | Two DDR bytes to drive this cycle, first byte in 15:8 |
| hb_dq_oe | output | 1 | DQ output enable |
| hb_rwds_o | output | 2 | Write byte mask per DDR half |
| hb_rwds_oe | output | 1 | Strobe output enable |
| hb_rwds_i | input | 1 | Strobe level from the device |
| rx_data | input | 16 | Word from the receive FIFO |
| rx_valid | input | 1 | Receive FIFO word valid |

## Verification
The hardest case to reach from the ports is a write whose data phase pauses the device clock in the middle of a burst. The same write must also carry partial byte masks under doubled latency. Its effect on memory is only visible through a later read that passes through the skipped-word receive path. The stimulus drives a behavioural device model that decodes the command words and counts its own latency from the strobe level it presents. The write burst withholds one beat and masks single bytes. A read of the same range under doubled latency then has to return the merged contents word for word, with the junk lead word removed.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int WORD_W = 16;
    localparam int CA_W   = 48;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_LAT,
        ST_WR,
        ST_RDCK,
        ST_RDWT,
        ST_RECOV
    } seq_state_e;

    typedef struct packed {
        logic        rd;
        logic        reg_space;
        logic        linear;
        logic [28:0] upper;
        logic [12:0] zero;
        logic [2:0]  lower;
    } cmd_word_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [1:0]        mask;
    } wr_beat_t;

    function automatic cmd_word_t make_cmd(input logic rd, input logic [31:0] waddr);
        cmd_word_t c;
        c.rd        = rd;
        c.reg_space = 1'b0;
        c.linear    = 1'b1;
        c.upper     = waddr[31:3];
        c.zero      = '0;
        c.lower     = waddr[2:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cmd_slice(input cmd_word_t c, input logic [1:0] idx);
        logic [CA_W-1:0] v;
        v = c;
        case (idx)
            2'd0:    return v[47:32];
            2'd1:    return v[31:16];
            default: return v[15:0];
        endcase
    endfunction

endpackage

// File: rtl/hbus_lat_ctl.sv
module hbus_lat_ctl #(
    parameter int LAT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic load,
    input  logic run,
    input  logic rwds_i,
    output logic done
);
    localparam int CNT_W = $clog2(2 * LAT_CYC + 1);

    logic             dbl_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dbl_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (sample) begin
                dbl_q <= rwds_i;
            end
            if (load) begin
                cnt_q <= dbl_q ? CNT_W'(2 * LAT_CYC - 1) : CNT_W'(LAT_CYC - 1);
            end else if (run && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = run && (cnt_q == '0);

    // R3: the latency choice stays fixed while latency runs
    a_r3_dbl_stable: assert property (@(posedge clk) disable iff (rst)
        run |-> $stable(dbl_q));

endmodule

// File: rtl/hbus_wr_beat.sv
module hbus_wr_beat
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              wr_phase,
    input  logic              av_write,
    input  logic [WORD_W-1:0] av_writedata,
    input  logic [1:0]        av_byteenable,
    output wr_beat_t          beat,
    output logic              sent,
    output logic              held
);
    logic     held_q;
    wr_beat_t hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            hold_q <= '0;
        end else if (cap) begin
            held_q <= 1'b1;
            hold_q <= wr_beat_t'{data: av_writedata, mask: ~av_byteenable};
        end else if (wr_phase && held_q) begin
            held_q <= 1'b0;
        end
    end

    assign beat = held_q ? hold_q : wr_beat_t'{data: av_writedata, mask: ~av_byteenable};
    assign sent = wr_phase && (held_q || av_write);
    assign held = held_q;

    // R4: the captured first beat only leaves during the data phase
    a_r4_held_sent: assert property (@(posedge clk) disable iff (rst)
        $fell(held_q) |-> $past(wr_phase));

endmodule

// File: rtl/hbus_rd_drop.sv
module hbus_rd_drop #(
    parameter int BURST_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [BURST_W-1:0] burst,
    input  logic               active,
    input  logic               rx_valid,
    output logic               fwd,
    output logic               last
);
    logic               first_q;
    logic [BURST_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            left_q  <= '0;
        end else if (start) begin
            first_q <= 1'b1;
            left_q  <= burst;
        end else if (active && rx_valid) begin
            if (first_q) begin
                first_q <= 1'b0;
            end else if (left_q != '0) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign fwd  = active && rx_valid && !first_q && (left_q != '0);
    assign last = fwd && (left_q == BURST_W'(1));

    // R8: nothing is forwarded in the cycle after the final word
    a_r8_no_extra: assert property (@(posedge clk) disable iff (rst)
        last |=> !fwd);

endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
    import hbus_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int BURST_W   = 8,
    parameter int LAT_CYC   = 4,
    parameter int RECOV_CYC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  av_address,
    input  logic               av_read,
    input  logic               av_write,
    input  logic [15:0]        av_writedata,
    input  logic [1:0]         av_byteenable,
    input  logic [BURST_W-1:0] av_burstcount,
    output logic               av_waitrequest,
    output logic [15:0]        av_readdata,
    output logic               av_readdatavalid,
    output logic               hb_cs_n,
    output logic               hb_ck_en,
    output logic [15:0]        hb_dq_o,
    output logic               hb_dq_oe,
    output logic [1:0]         hb_rwds_o,
    output logic               hb_rwds_oe,
    input  logic               hb_rwds_i,
    input  logic [15:0]        rx_data,
    input  logic               rx_valid
);
    localparam int CK_W  = BURST_W + 1;
    localparam int REC_W = $clog2(RECOV_CYC + 1);

    seq_state_e         st_q;
    logic [1:0]         idx_q;
    logic               is_rd_q;
    cmd_word_t          cmd_q;
    logic [BURST_W-1:0] beats_q;
    logic [CK_W-1:0]    clks_q;
    logic [REC_W-1:0]   rec_q;

    logic     accept, lat_done, wr_sent, wr_held, rd_fwd, rd_last, rd_active;
    wr_beat_t beat;

    assign accept    = (st_q == ST_IDLE) && (av_read || av_write);
    assign rd_active = (st_q == ST_RDCK) || (st_q == ST_RDWT);

    hbus_lat_ctl #(.LAT_CYC(LAT_CYC)) lat_i (
        .clk    (clk),
        .rst    (rst),
        .sample (st_q == ST_CMD && idx_q == 2'd0),
        .load   (st_q == ST_CMD && idx_q == 2'd2),
        .run    (st_q == ST_LAT),
        .rwds_i (hb_rwds_i),
        .done   (lat_done)
    );

    hbus_wr_beat wr_i (
        .clk           (clk),
        .rst           (rst),
        .cap           (accept && !av_read),
        .wr_phase      (st_q == ST_WR),
        .av_write      (av_write),
        .av_writedata  (av_writedata),
        .av_byteenable (av_byteenable),
        .beat          (beat),
        .sent          (wr_sent),
        .held          (wr_held)
    );

    hbus_rd_drop #(.BURST_W(BURST_W)) rd_i (
        .clk      (clk),
        .rst      (rst),
        .start    (accept && av_read),
        .burst    (av_burstcount),
        .active   (rd_active),
        .rx_valid (rx_valid),
        .fwd      (rd_fwd),
        .last     (rd_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            is_rd_q <= 1'b0;
            cmd_q   <= '0;
            beats_q <= '0;
            clks_q  <= '0;
            rec_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        st_q    <= ST_CMD;
                        idx_q   <= '0;
                        is_rd_q <= av_read;
                        cmd_q   <= make_cmd(av_read, 32'(av_address));
                        beats_q <= av_burstcount;
                        clks_q  <= CK_W'(av_burstcount) + CK_W'(1);
                    end
                end
                ST_CMD: begin
                    idx_q <= idx_q + 2'd1;
                    if (idx_q == 2'd2) begin
                        st_q <= ST_LAT;
                    end
                end
                ST_LAT: begin
                    if (lat_done) begin
                        st_q <= is_rd_q ? ST_RDCK : ST_WR;
                    end
                end
                ST_WR: begin
                    if (wr_sent) begin
                        beats_q <= beats_q - 1'b1;
                        if (beats_q == BURST_W'(1)) begin
                            st_q  <= ST_RECOV;
                            rec_q <= REC_W'(RECOV_CYC - 1);
                        end
                    end
                end
                ST_RDCK: begin
                    clks_q <= clks_q - 1'b1;
                    if (rd_last) begin
                        st_q  <= ST_RECOV;
                        rec_q <= REC_W'(RECOV_CYC - 1);
                    end else if (clks_q == CK_W'(1)) begin
                        st_q <= ST_RDWT;
                    end
                end
                ST_RDWT: begin
                    if (rd_last) begin
                        st_q  <= ST_RECOV;
                        rec_q <= REC_W'(RECOV_CYC - 1);
                    end
                end
                ST_RECOV: begin
                    if (rec_q == '0) begin
                        st_q <= ST_IDLE;
                    end else begin
                        rec_q <= rec_q - 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign hb_cs_n = !(st_q == ST_CMD || st_q == ST_LAT || st_q == ST_WR || st_q == ST_RDCK);
    assign hb_ck_en = (st_q == ST_CMD) || (st_q == ST_LAT) || (st_q == ST_RDCK)
                    || (st_q == ST_WR && wr_sent);
    assign hb_dq_oe   = (st_q == ST_CMD) || (st_q == ST_WR);
    assign hb_dq_o    = (st_q == ST_CMD) ? cmd_slice(cmd_q, idx_q) : beat.data;
    assign hb_rwds_oe = (st_q == ST_WR);
    assign hb_rwds_o  = beat.mask;

    assign av_waitrequest   = !((st_q == ST_IDLE) || (st_q == ST_WR && !wr_held));
    assign av_readdata      = rx_data;
    assign av_readdatavalid = rd_fwd;

    // R1: a taken request makes the port busy in the next cycle
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> av_waitrequest);

    // R9: chip select never pulses high for a single cycle only
    a_r9_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(hb_cs_n) |=> hb_cs_n);

    // R7: the read clock stops no later than chip select rises
    a_r7_no_clock_cs_high: assert property (@(posedge clk) disable iff (rst)
        hb_cs_n |-> !hb_ck_en);

endmodule

// File: tb/hbus_seq_tb_top.sv
module hbus_seq_tb_top;

    localparam int L  = 4;
    localparam int RC = 4;
    localparam int D  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] av_address = '0;
    logic        av_read = 1'b0;
    logic        av_write = 1'b0;
    logic [15:0] av_writedata = '0;
    logic [1:0]  av_byteenable = '0;
    logic [7:0]  av_burstcount = 8'd1;
    logic        av_waitrequest, av_readdatavalid;
    logic [15:0] av_readdata;
    logic        hb_cs_n, hb_ck_en, hb_dq_oe, hb_rwds_oe;
    logic [15:0] hb_dq_o;
    logic [1:0]  hb_rwds_o;
    logic        dev_dbl = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_valid = 1'b0;

    always #10 clk = ~clk;

    hbus_seq dut_i (
        .clk(clk), .rst(rst), .av_address(av_address), .av_read(av_read),
        .av_write(av_write), .av_writedata(av_writedata), .av_byteenable(av_byteenable),
        .av_burstcount(av_burstcount), .av_waitrequest(av_waitrequest),
        .av_readdata(av_readdata), .av_readdatavalid(av_readdatavalid),
        .hb_cs_n(hb_cs_n), .hb_ck_en(hb_ck_en), .hb_dq_o(hb_dq_o), .hb_dq_oe(hb_dq_oe),
        .hb_rwds_o(hb_rwds_o), .hb_rwds_oe(hb_rwds_oe), .hb_rwds_i(dev_dbl),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    int total = 0;
    int bad = 0;

    logic [15:0] dmem [256];
    logic [15:0] emem [256];
    logic [15:0] wd [8];
    logic [1:0]  wb [8];

    task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_cmd(input logic rd, input int a);
        return {rd, 1'b0, 1'b1, 29'(a >> 3), 13'd0, 3'(a % 8)};
    endfunction

    // behavioural device: decodes the command, counts its own latency, returns via a delay line
    int          dcnt = 0;
    logic [47:0] dca = '0;
    logic        d_rd = 1'b0;
    int          d_addr = 0;
    int          d_idx = 0;
    logic        pv [D];
    logic [15:0] pd [D];

    initial begin
        for (int i = 0; i < D; i++) begin
            pv[i] = 1'b0;
            pd[i] = '0;
        end
        forever begin
            @(negedge clk);
            rx_valid = pv[D-1];
            rx_data  = pd[D-1];
            for (int i = D - 1; i > 0; i--) begin
                pv[i] = pv[i-1];
                pd[i] = pd[i-1];
            end
            pv[0] = 1'b0;
            #2;
            if (hb_cs_n !== 1'b0) begin
                dcnt = 0;
            end else if (hb_ck_en === 1'b1) begin
                dcnt++;
                if (dcnt <= 3) begin
                    dca = {dca[31:0], hb_dq_o};
                    if (dcnt == 3) begin
                        d_rd   = dca[47];
                        d_addr = int'({dca[44:16], dca[2:0]});
                        d_idx  = 0;
                    end
                end else if (dcnt > 3 + (dev_dbl ? 2 * L : L)) begin
                    if (d_rd) begin
                        pv[0] = 1'b1;
                        pd[0] = (d_idx == 0) ? 16'hDEAD : dmem[(d_addr + d_idx - 1) % 256];
                    end else begin
                        if (!hb_rwds_o[1]) dmem[(d_addr + d_idx) % 256][15:8] = hb_dq_o[15:8];
                        if (!hb_rwds_o[0]) dmem[(d_addr + d_idx) % 256][7:0]  = hb_dq_o[7:0];
                    end
                    d_idx++;
                end
            end
        end
    end

    task automatic check_idle(input string req);
        chk(req, "idle waitrequest", 48'(av_waitrequest), 48'd0);
        chk(req, "idle cs_n", 48'(hb_cs_n), 48'd1);
        chk(req, "idle ck_en", 48'(hb_ck_en), 48'd0);
    endtask

    task automatic check_cmd(input int c, input logic [47:0] cw);
        logic [15:0] w;
        w = (c == 1) ? cw[47:32] : (c == 2) ? cw[31:16] : cw[15:0];
        chk("R2", "command word", 48'(hb_dq_o), 48'(w));
        chk("R2", "command cs/ck/oe/wait", {44'd0, hb_cs_n, hb_ck_en, hb_dq_oe, av_waitrequest},
            48'b0111);
    endtask

    task automatic check_lat();
        chk("R3", "latency cs/ck/oe/wait", {44'd0, hb_cs_n, hb_ck_en, hb_dq_oe, av_waitrequest},
            48'b0101);
    endtask

    task automatic run_write(input int a, input int n, input logic dbl, input int gap_at);
        int le, k, rstart;
        logic gap_done;
        logic [47:0] cw;
        le = dbl ? 2 * L : L;
        dev_dbl = dbl;
        cw = exp_cmd(1'b0, a);
        for (int i = 0; i < n; i++) begin
            if (wb[i][1]) emem[(a + i) % 256][15:8] = wd[i][15:8];
            if (wb[i][0]) emem[(a + i) % 256][7:0]  = wd[i][7:0];
        end
        @(negedge clk);
        av_address = 22'(a); av_write = 1'b1; av_writedata = wd[0];
        av_byteenable = wb[0]; av_burstcount = 8'(n);
        #1;
        check_idle("R1");
        k = 1; gap_done = 1'b0; rstart = 5 + le;
        for (int c = 1; c < 1000; c++) begin
            @(negedge clk);
            if (c == 1) av_write = 1'b0;
            if (c <= 3) begin
                #1; check_cmd(c, cw);
            end else if (c <= 3 + le) begin
                #1; check_lat();
            end else if (c == 4 + le) begin
                #1;
                chk("R4", "held beat data", 48'(hb_dq_o), 48'(wd[0]));
                chk("R4", "held beat ck/wait/cs", {45'd0, hb_ck_en, av_waitrequest, hb_cs_n}, 48'b110);
                chk("R5", "held beat mask", {45'd0, hb_rwds_oe, hb_rwds_o}, {45'd0, 1'b1, ~wb[0]});
            end else if (k < n) begin
                if (k == gap_at && !gap_done) begin
                    gap_done = 1'b1;
                    av_write = 1'b0;
                    #1;
                    chk("R6", "pause ck/wait/cs", {45'd0, hb_ck_en, av_waitrequest, hb_cs_n}, 48'b000);
                end else begin
                    av_write = 1'b1; av_writedata = wd[k]; av_byteenable = wb[k];
                    #1;
                    chk("R4", "beat data", 48'(hb_dq_o), 48'(wd[k]));
                    chk("R4", "beat ck/wait/cs", {45'd0, hb_ck_en, av_waitrequest, hb_cs_n}, 48'b100);
                    chk("R5", "beat mask", {45'd0, hb_rwds_oe, hb_rwds_o}, {45'd0, 1'b1, ~wb[k]});
                    k++;
                    rstart = c + 1;
                end
            end else if (c < rstart + RC) begin
                av_write = 1'b0;
                #1;
                chk("R9", "write recovery cs/wait/ck", {45'd0, hb_cs_n, av_waitrequest, hb_ck_en}, 48'b110);
            end else begin
                #1;
                check_idle("R1");
                break;
            end
        end
    endtask

    task automatic run_read(input int a, input int n, input logic dbl);
        int le;
        logic exp_v;
        logic [47:0] cw;
        le = dbl ? 2 * L : L;
        dev_dbl = dbl;
        cw = exp_cmd(1'b1, a);
        @(negedge clk);
        av_address = 22'(a); av_read = 1'b1; av_burstcount = 8'(n);
        #1;
        check_idle("R1");
        for (int c = 1; c < 1000; c++) begin
            @(negedge clk);
            if (c == 1) av_read = 1'b0;
            #1;
            if (c <= 3) begin
                check_cmd(c, cw);
            end else if (c <= 3 + le) begin
                check_lat();
            end else if (c <= 4 + le + n) begin
                chk("R7", "read clock cs/ck/oe/wait", {44'd0, hb_cs_n, hb_ck_en, hb_dq_oe, av_waitrequest},
                    48'b0101);
            end else if (c <= 6 + le + n) begin
                chk("R7", "read tail cs/ck/wait", {45'd0, hb_cs_n, hb_ck_en, av_waitrequest}, 48'b101);
            end else if (c <= 6 + le + n + RC) begin
                chk("R9", "read recovery cs/wait/ck", {45'd0, hb_cs_n, av_waitrequest, hb_ck_en}, 48'b110);
            end else begin
                check_idle("R1");
                break;
            end
            if (c >= 4 + le) begin
                exp_v = (c >= 7 + le) && (c <= 6 + le + n);
                chk("R8", "readdatavalid", 48'(av_readdatavalid), 48'(exp_v));
                if (exp_v) begin
                    chk("R8", "readdata", 48'(av_readdata), 48'(emem[(a + c - 7 - le) % 256]));
                end
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            dmem[i] = 16'(i * 37 + 3);
            emem[i] = 16'(i * 37 + 3);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check_idle("R1");
        chk("R1", "reset readdatavalid/oe", {46'd0, av_readdatavalid, hb_dq_oe}, 48'd0);

        // single word, single latency
        wd[0] = 16'h1234; wb[0] = 2'b11;
        run_write(5, 1, 1'b0, 0);
        run_read(5, 1, 1'b0);

        // R5/R6: masked bytes and a clock pause under doubled latency
        wd[0] = 16'hA1A2; wb[0] = 2'b11;
        wd[1] = 16'hB1B2; wb[1] = 2'b01;
        wd[2] = 16'hC1C2; wb[2] = 2'b10;
        wd[3] = 16'hD1D2; wb[3] = 2'b11;
        run_write(16, 4, 1'b1, 2);
        run_read(16, 4, 1'b1);

        // fully masked first beat, pause before the second beat
        wd[0] = 16'hEEEE; wb[0] = 2'b00;
        wd[1] = 16'h7777; wb[1] = 2'b11;
        wd[2] = 16'h8888; wb[2] = 2'b11;
        run_write(6, 3, 1'b0, 1);

        // burst across the low address field boundary
        run_read(4, 6, 1'b0);
        // nonzero upper address bits, doubled latency
        run_read(200, 5, 1'b1);

        // write straight into a read
        wd[0] = 16'h0F0F; wb[0] = 2'b11;
        wd[1] = 16'hF0F0; wb[1] = 2'b11;
        run_write(9, 2, 1'b1, 0);
        run_read(8, 3, 1'b0);

        // R1: read wins when both requests are raised together
        @(negedge clk);
        av_address = 22'd40; av_read = 1'b1; av_write = 1'b1; av_burstcount = 8'd1;
        @(negedge clk);
        av_read = 1'b0; av_write = 1'b0;
        #1;
        chk("R1", "read priority command bit", 48'(hb_dq_o[15]), 48'd1);
        repeat (40) @(negedge clk);
        #1;
        check_idle("R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule